// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits beside one processor and presents at most one interrupt to it at a time. It holds five pieces of state: the processor's current priority, the priority of a pending inter-processor request, a 24-bit number for the pending source, the priority of that source, and a flag that records that some delivery was refused. Priority numbers work in reverse: a smaller number is more favored. The value 0xFF means "masked" or "nothing pending".

Source controllers offer deliveries, each with a source number and a priority. The block accepts or refuses each one. When a more favored delivery displaces a pending source, the displaced number goes back out on a reject port so its source can try again later. Refused deliveries are remembered in one flag. When the processor later lowers its priority, or raises the inter-processor priority value, the flag comes out as a one-cycle resend pulse.

The processor drives four commands: read-and-accept, set priority, end-of-interrupt and set the inter-processor priority. The inter-processor request competes for the single slot under the fixed source number 2. All state changes are atomic and take one clock. All outputs are registered and appear one cycle after the inputs that cause them.

Top module: `intr_presenter`

## Requirements
- R1: A synchronous reset sets the current priority to 0, the pending source to 0, and both the inter-processor priority and the pending priority to 0xFF. It also clears the refusal flag. An accept command issued straight after reset therefore returns 0x00000000.
- R2: irq_out is high exactly when the registered pending source is nonzero and the pending priority is strictly less than the current priority.
- R3: A delivery with no command in the same cycle is accepted (dlv_ack the next cycle) only if its priority is strictly less than each of the current priority, the inter-processor priority and the pending priority. It then becomes the pending source at that priority. Otherwise dlv_nack is raised the next cycle.
- R4: On an accepted delivery, the source that was pending before is reported on the reject port.
- R5: A refused delivery sets the refusal flag. The flag is seen later as resend_pulse.
- R6: Command 0 (accept) returns, on the next cycle, rd_word = {current priority in bits 31:24, pending source in bits 23:0}. If the pending source was nonzero, the current priority takes the pending priority, the pending priority becomes 0xFF and the pending source becomes 0.
- R7: Command 1 (set priority, value in cmd_data[7:0]) with a value below the current priority loads it. If the value is also less than or equal to the pending priority, the pending source is rejected and cleared, and the pending priority becomes 0xFF.
- R8: Command 1 with a value equal to the current priority changes nothing and produces no output event.
- R9: Command 1 with a value above the current priority loads it. Then, if the inter-processor priority is below the new value and less than or equal to the pending priority, source 2 becomes pending at the inter-processor priority. The refusal flag is copied to resend_pulse and cleared.
- R10: Command 3 (value in cmd_data[7:0]) stores the inter-processor priority. If the new value is below the current priority, source 2 becomes pending at that priority, and the old pending source is rejected when the value is less than or equal to the old pending priority.
- R11: If command 3 writes a value larger than both the old inter-processor priority and the current priority, the refusal flag is copied to resend_pulse and cleared.
- R12: Command 2 (end-of-interrupt) takes the new priority from cmd_data[31:24] and always runs the R9 path, with no rejection check. It raises eoi_valid with eoi_src = cmd_data[23:0] unless that field equals 2.
- R13: A rejected source number of 0 or 2 is dropped and never appears on rej_valid.
- R14: A command and a delivery in the same cycle: the command is applied and the delivery is refused (dlv_nack). The refusal flag is then set after the command's own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | Delivery offered this cycle |
| dlv_src | input | 24 | Source number of the delivery |
| dlv_pri | input | 8 | Priority of the delivery |
| dlv_ack | output | 1 | Delivery accepted (one cycle later) |
| dlv_nack | output | 1 | Delivery refused (one cycle later) |
| cmd_valid | input | 1 | Processor command this cycle |
| cmd_op | input | 2 | 0 accept, 1 set priority, 2 end-of-interrupt, 3 set inter-processor priority |
| cmd_data | input | 32 | Command operand |
| rd_valid | output | 1 | rd_word holds an accept result |
| rd_word | output | 32 | {priority, source} returned by accept |
| rej_valid | output | 1 | A displaced source is returned |
| rej_src | output | 24 | Number of the displaced source |
| resend_pulse | output | 1 | Refused deliveries should be offered again |
| eoi_valid | output | 1 | End-of-interrupt notice for a source controller |
| eoi_src | output | 24 | Source named by the end-of-interrupt |
| irq_out | output | 1 | Interrupt request toward the processor |

## Verification
The hardest state to reach is a pending inter-processor request that sits next to a refused delivery still recorded in the flag. The flag must then be released through the raise-the-inter-processor-value path and not through a priority drop. A directed sequence builds this step by step. It sets a favored inter-processor priority below the current priority, offers a delivery that loses to it, and then writes a larger inter-processor value. A long pseudo-random stream of mixed commands, deliveries and collisions then runs against an arithmetic model of the five state fields. It uses a few priorities near each other, so that equal and off-by-one comparisons occur often.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int PRI_W = 8;
  localparam int SRC_W = 24;
  localparam int CMD_W = PRI_W + SRC_W;
  localparam logic [PRI_W-1:0] PRI_NONE = '1;

  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_SET_PRIO = 2'd1,
    OP_EOI      = 2'd2,
    OP_SET_IPI  = 2'd3
  } op_e;

  typedef struct packed {
    logic [PRI_W-1:0] cur_pri;
    logic [PRI_W-1:0] ipi_pri;
    logic [PRI_W-1:0] pend_pri;
    logic [SRC_W-1:0] pend_src;
    logic             refused;
  } ipc_state_t;
endpackage

// File: rtl/ipc_next.sv
module ipc_next
  import ipc_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  ipc_state_t       st,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             dlv_valid,
  input  logic [SRC_W-1:0] dlv_src,
  input  logic [PRI_W-1:0] dlv_pri,
  output ipc_state_t       st_n,
  output logic             ack,
  output logic             nack,
  output logic [SRC_W-1:0] raw_rej,
  output logic             resend,
  output logic             rd_valid,
  output logic [CMD_W-1:0] rd_word,
  output logic             eoi_valid,
  output logic [SRC_W-1:0] eoi_src
);
  logic [PRI_W-1:0] val;
  logic [PRI_W-1:0] top_pri;
  op_e              op;

  assign val     = cmd_data[PRI_W-1:0];
  assign top_pri = cmd_data[CMD_W-1:SRC_W];
  assign op      = op_e'(cmd_op);

  always_comb begin
    st_n      = st;
    ack       = 1'b0;
    nack      = 1'b0;
    raw_rej   = '0;
    resend    = 1'b0;
    rd_valid  = 1'b0;
    rd_word   = '0;
    eoi_valid = 1'b0;
    eoi_src   = '0;
    if (cmd_valid) begin
      unique case (op)
        OP_ACCEPT: begin
          rd_valid = 1'b1;
          rd_word  = {st.cur_pri, st.pend_src};
          if (st.pend_src != '0) begin
            st_n.cur_pri  = st.pend_pri;
            st_n.pend_pri = PRI_NONE;
            st_n.pend_src = '0;
          end
        end
        OP_SET_PRIO: begin
          if (val < st.cur_pri) begin
            st_n.cur_pri = val;
            if (val <= st.pend_pri) begin
              raw_rej       = st.pend_src;
              st_n.pend_src = '0;
              st_n.pend_pri = PRI_NONE;
            end
          end else if (val > st.cur_pri) begin
            st_n.cur_pri = val;
            if (st.ipi_pri < val && st.ipi_pri <= st.pend_pri) begin
              st_n.pend_pri = st.ipi_pri;
              st_n.pend_src = IPI_SRC;
            end
            resend       = st.refused;
            st_n.refused = 1'b0;
          end
        end
        OP_EOI: begin
          st_n.cur_pri = top_pri;
          if (st.ipi_pri < top_pri && st.ipi_pri <= st.pend_pri) begin
            st_n.pend_pri = st.ipi_pri;
            st_n.pend_src = IPI_SRC;
          end
          resend       = st.refused;
          st_n.refused = 1'b0;
          if (cmd_data[SRC_W-1:0] != IPI_SRC) begin
            eoi_valid = 1'b1;
            eoi_src   = cmd_data[SRC_W-1:0];
          end
        end
        OP_SET_IPI: begin
          st_n.ipi_pri = val;
          if (val < st.cur_pri) begin
            if (val <= st.pend_pri) raw_rej = st.pend_src;
            st_n.pend_pri = val;
            st_n.pend_src = IPI_SRC;
          end
          if (val > st.ipi_pri && val > st.cur_pri) begin
            resend       = st.refused;
            st_n.refused = 1'b0;
          end
        end
        default: ;
      endcase
    end
    if (dlv_valid) begin
      if (!cmd_valid && dlv_pri < st.cur_pri && dlv_pri < st.ipi_pri &&
          dlv_pri < st.pend_pri) begin
        ack           = 1'b1;
        raw_rej       = st.pend_src;
        st_n.pend_src = dlv_src;
        st_n.pend_pri = dlv_pri;
      end else begin
        nack         = 1'b1;
        st_n.refused = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipc_bounce.sv
module ipc_bounce
  import ipc_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] raw_rej,
  output logic             rej_valid,
  output logic [SRC_W-1:0] rej_src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rej_valid <= 1'b0;
      rej_src   <= '0;
    end else begin
      rej_valid <= (raw_rej != '0) && (raw_rej != IPI_SRC);
      rej_src   <= raw_rej;
    end
  end

  // R13
  rej_filter_chk: assert property (@(posedge clk) disable iff (rst)
    rej_valid |-> (rej_src != '0 && rej_src != IPI_SRC));
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import ipc_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dlv_valid,
  input  logic [SRC_W-1:0] dlv_src,
  input  logic [PRI_W-1:0] dlv_pri,
  output logic             dlv_ack,
  output logic             dlv_nack,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             rd_valid,
  output logic [CMD_W-1:0] rd_word,
  output logic             rej_valid,
  output logic [SRC_W-1:0] rej_src,
  output logic             resend_pulse,
  output logic             eoi_valid,
  output logic [SRC_W-1:0] eoi_src,
  output logic             irq_out
);
  ipc_state_t       st_q, st_n;
  logic             ack_n, nack_n, resend_n, rdv_n, eoiv_n;
  logic [SRC_W-1:0] rej_n, eois_n;
  logic [CMD_W-1:0] rd_n;

  ipc_next #(.IPI_SRC(IPI_SRC)) u_next (
    .st(st_q), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_pri(dlv_pri),
    .st_n(st_n), .ack(ack_n), .nack(nack_n), .raw_rej(rej_n),
    .resend(resend_n), .rd_valid(rdv_n), .rd_word(rd_n),
    .eoi_valid(eoiv_n), .eoi_src(eois_n)
  );

  ipc_bounce #(.IPI_SRC(IPI_SRC)) u_bounce (
    .clk(clk), .rst(rst), .raw_rej(rej_n),
    .rej_valid(rej_valid), .rej_src(rej_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q.cur_pri  <= '0;
      st_q.ipi_pri  <= PRI_NONE;
      st_q.pend_pri <= PRI_NONE;
      st_q.pend_src <= '0;
      st_q.refused  <= 1'b0;
      dlv_ack       <= 1'b0;
      dlv_nack      <= 1'b0;
      rd_valid      <= 1'b0;
      rd_word       <= '0;
      resend_pulse  <= 1'b0;
      eoi_valid     <= 1'b0;
      eoi_src       <= '0;
      irq_out       <= 1'b0;
    end else begin
      st_q         <= st_n;
      dlv_ack      <= ack_n;
      dlv_nack     <= nack_n;
      rd_valid     <= rdv_n;
      rd_word      <= rd_n;
      resend_pulse <= resend_n;
      eoi_valid    <= eoiv_n;
      eoi_src      <= eois_n;
      irq_out      <= (st_n.pend_src != '0) && (st_n.pend_pri < st_n.cur_pri);
    end
  end

  // R2
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == (st_q.pend_src != '0 && st_q.pend_pri < st_q.cur_pri));
  // R3
  dlv_win_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !cmd_valid && dlv_pri < st_q.cur_pri &&
     dlv_pri < st_q.ipi_pri && dlv_pri < st_q.pend_pri) |=> dlv_ack);
  // R14
  cmd_first_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && cmd_valid) |=> (dlv_nack && !dlv_ack));
  // R6
  rd_word_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ACCEPT) |=>
      (rd_valid && rd_word == {$past(st_q.cur_pri), $past(st_q.pend_src)}));
  // R8
  eq_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SET_PRIO && cmd_data[PRI_W-1:0] == st_q.cur_pri &&
     !dlv_valid) |=> ($stable(st_q) && !rej_valid && !resend_pulse));
  // R12
  eoi_ipi_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_EOI && cmd_data[SRC_W-1:0] == IPI_SRC) |=> !eoi_valid);
endmodule

// File: tb/intr_presenter_tb.sv
module intr_presenter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dlv_valid = 1'b0;
  logic [23:0] dlv_src = '0;
  logic [7:0]  dlv_pri = '0;
  logic        dlv_ack, dlv_nack;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        rd_valid;
  logic [31:0] rd_word;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic        resend_pulse, eoi_valid, irq_out;
  logic [23:0] eoi_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  m_cur, m_ipi, m_pend;
  logic [23:0] m_src;
  logic        m_ref;
  logic [31:0] lfsr = 32'hACE1_1234;

  localparam logic [1:0] ACC = 2'd0, SETP = 2'd1, EOI = 2'd2, SETI = 2'd3;

  always #10 clk = ~clk;

  intr_presenter u_dut (
    .clk(clk), .rst(rst), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
    .dlv_pri(dlv_pri), .dlv_ack(dlv_ack), .dlv_nack(dlv_nack),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_word(rd_word), .rej_valid(rej_valid),
    .rej_src(rej_src), .resend_pulse(resend_pulse), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic down_path(input logic [7:0] v, inout logic res);
    m_cur = v;
    if (m_ipi < v && m_ipi <= m_pend) begin
      m_pend = m_ipi;
      m_src  = 24'd2;
    end
    res   = m_ref;
    m_ref = 1'b0;
  endtask

  task automatic do_op(input logic cv, input logic [1:0] op, input logic [31:0] d,
                       input logic dv, input logic [23:0] s, input logic [7:0] p,
                       input string tag);
    logic e_ack = 0, e_nack = 0, e_res = 0, e_rdv = 0, e_ev = 0, e_rv;
    logic [31:0] e_rd = '0;
    logic [23:0] e_es = '0, raw = '0;
    logic [7:0]  om;
    if (cv) begin
      case (op)
        ACC: begin
          e_rdv = 1; e_rd = {m_cur, m_src};
          if (m_src != 0) begin m_cur = m_pend; m_pend = 8'hFF; m_src = 0; end
        end
        SETP: begin
          if (d[7:0] < m_cur) begin
            m_cur = d[7:0];
            if (d[7:0] <= m_pend) begin raw = m_src; m_src = 0; m_pend = 8'hFF; end
          end else if (d[7:0] > m_cur) down_path(d[7:0], e_res);
        end
        EOI: begin
          down_path(d[31:24], e_res);
          if (d[23:0] != 24'd2) begin e_ev = 1; e_es = d[23:0]; end
        end
        default: begin
          om = m_ipi; m_ipi = d[7:0];
          if (d[7:0] < m_cur) begin
            if (d[7:0] <= m_pend) raw = m_src;
            m_pend = d[7:0]; m_src = 24'd2;
          end
          if (d[7:0] > om && d[7:0] > m_cur) begin e_res = m_ref; m_ref = 0; end
        end
      endcase
    end
    if (dv) begin
      if (!cv && p < m_cur && p < m_ipi && p < m_pend) begin
        e_ack = 1; raw = m_src; m_src = s; m_pend = p;
      end else begin
        e_nack = 1; m_ref = 1;
      end
    end
    e_rv = (raw != 0) && (raw != 24'd2);
    cmd_valid = cv; cmd_op = op; cmd_data = d;
    dlv_valid = dv; dlv_src = s; dlv_pri = p;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; dlv_valid = 0;
    chk({tag, " ack"}, 32'(dlv_ack), 32'(e_ack));
    chk({tag, " nack"}, 32'(dlv_nack), 32'(e_nack));
    chk({tag, " rej_valid"}, 32'(rej_valid), 32'(e_rv));
    if (e_rv) chk({tag, " rej_src"}, 32'(rej_src), 32'(raw));
    chk({tag, " resend"}, 32'(resend_pulse), 32'(e_res));
    chk({tag, " rd_valid"}, 32'(rd_valid), 32'(e_rdv));
    if (e_rdv) chk({tag, " rd_word"}, rd_word, e_rd);
    chk({tag, " eoi_valid"}, 32'(eoi_valid), 32'(e_ev));
    if (e_ev) chk({tag, " eoi_src"}, 32'(eoi_src), 32'(e_es));
    chk("R2 irq_out", 32'(irq_out), 32'((m_src != 0) && (m_pend < m_cur)));
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_cur = 0; m_ipi = 8'hFF; m_pend = 8'hFF; m_src = 0; m_ref = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 irq after reset", 32'(irq_out), 0);
    do_op(1, ACC, 0, 0, 0, 0, "R1");
    do_op(0, ACC, 0, 1, 24'h100, 8'd5, "R3 refused at prio 0");
    do_op(1, SETP, 32'hFF, 0, 0, 0, "R5 R9 lower prio");
    do_op(0, ACC, 0, 1, 24'h100, 8'd5, "R3 accepted");
    do_op(0, ACC, 0, 1, 24'h200, 8'd3, "R4 displace");
    do_op(0, ACC, 0, 1, 24'h300, 8'd3, "R3 equal refused");
    do_op(1, ACC, 0, 0, 0, 0, "R6 accept");
    do_op(0, ACC, 0, 1, 24'h400, 8'd2, "R3 beats new prio");
    do_op(1, SETP, 32'h03, 0, 0, 0, "R8 equal prio");
    do_op(1, SETP, 32'h01, 0, 0, 0, "R7 raise rejects");
    do_op(1, SETI, 32'h00, 0, 0, 0, "R10 R13 ipi pending");
    do_op(1, ACC, 0, 0, 0, 0, "R6 accept ipi");
    do_op(1, EOI, 32'hFF00_0002, 0, 0, 0, "R12 eoi ipi");
    do_op(1, SETI, 32'hFF, 0, 0, 0, "R11 no resend");
    do_op(1, ACC, 0, 0, 0, 0, "R6 accept again");
    do_op(1, EOI, 32'h1000_0400, 0, 0, 0, "R12 eoi ext");
    do_op(1, ACC, 0, 1, 24'h500, 8'd1, "R14 collision");
    do_op(1, SETI, 32'h05, 0, 0, 0, "R10 ipi below prio");
    do_op(0, ACC, 0, 1, 24'h600, 8'd9, "R5 refused vs ipi");
    do_op(1, SETI, 32'h30, 0, 0, 0, "R11 resend");
    do_op(1, SETP, 32'h04, 0, 0, 0, "R13 ipi reject dropped");
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] sel;
      lfsr = step(step(step(lfsr)));
      sel = lfsr[2:0];
      do_op(sel[2] | sel[1], lfsr[4:3],
            {lfsr[9] ? 8'hFF : {5'd0, lfsr[7:5]}, 16'd0, lfsr[8] ? 8'd2 : 8'h33,
             lfsr[10] ? 8'hFF : {4'd0, lfsr[14:11]}},
            sel[0] | ~sel[1], {16'd0, lfsr[16] ? 8'h11 : (lfsr[17] ? 8'h22 : 8'h02)},
            {4'd0, lfsr[21:18]}, "R3 R9 R10 sweep");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule